// File: doc/BRIEF.md
# Field-repetition scan rate upconverter

This block turns an interlaced field stream into one at twice the field rate by showing every stored field two times. It sits between a video source and a display path. Its write side runs on a 27 MHz sample clock and its read side runs on an independent display clock. It drives a serial field memory only through pointer-reset and pointer-advance strobes, which it derives from the input and output vertical sync pulses. A behavioural dual-clock model of that memory is included, so the block simulates on its own.

The writer takes one 12-bit luma/chroma sample on every second write clock cycle. After each input vertical sync it fills `FIELD_LEN` locations starting at address zero, then stops. The reader restarts from address zero at every output vertical sync. Output syncs arrive twice per input field. After each restart the reader emits `FIELD_LEN` samples on consecutive read clocks. Raising or lowering the read clock frequency compresses or stretches the line in time, and this is how horizontal scaling is done. No interpolation is applied between the two showings.

A flag tells the first showing from the second. If an input sync arrives while the second showing is still being read, the next write reset is held back until that showing is finished, so no displayed field is ever a mix of two inputs. Sync pulses and flags that cross between the clocks pass through two-flop synchronizers.

Top module: `frc_upconv`

## Requirements
- R1: After reset `out_valid` is 0, and it stays 0 until a replay is started.
- R2: The writer stores one sample on every second write clock cycle while a field is being filled. Two samples stored one after the other were captured exactly two write clocks apart.
- R3: A rising edge on `in_vsync` resets the write pointer to address 0. Exactly `FIELD_LEN` samples are then stored, and nothing more is written until the next accepted input sync.
- R4: A rising edge on `out_vsync` starts a replay from address 0. The replay emits exactly `FIELD_LEN` samples with `out_valid` high on consecutive read clocks, and it does so for any ratio of read to write clock.
- R5: The first replay after a field finishes filling has `out_repeat`=0. The next replay has `out_repeat`=1 and carries bit-identical data.
- R6: If an input sync arrives while a replay with `out_repeat`=1 is running, no sample of the old field is overwritten until that replay ends. Writing of the new field then begins without a further sync.
- R7: An output sync that arrives before any field has finished filling starts no replay, so `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write (sample) clock |
| wrst_n | input | 1 | Synchronous active-low reset, write domain |
| in_vsync | input | 1 | Input vertical sync, asynchronous level, active high |
| in_data | input | DATA_W | Incoming sample, luma/chroma combined |
| rclk | input | 1 | Read (display) clock |
| rrst_n | input | 1 | Synchronous active-low reset, read domain |
| out_vsync | input | 1 | Output vertical sync, asynchronous level, active high |
| out_data | output | DATA_W | Replayed sample |
| out_valid | output | 1 | High when `out_data` carries a sample |
| out_repeat | output | 1 | 0 during the first showing of a field, 1 during the second |

## Verification
Every source sample carries a field number in its upper six bits and a free-running write-clock count in its lower six bits. Within a replay, a step of exactly two between neighbours confirms the alternate-cycle capture and the address order. Replays are run with read clocks faster than, equal-ish to, and slower than the write sample rate, and the two showings of each field are compared word for word. With a slow read clock, an input sync is placed inside a second showing. Without the hold-off, the faster writer would overtake the reader, and field numbers from two inputs would appear inside a single replay. An output sync sent before any field exists checks that no output appears.

// File: rtl/frc_pkg.sv
// Shared types for the field-repetition upconverter.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package frc_pkg;

    // Write-side controller states.
    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,   // field complete or none started
        WS_FILL = 2'd1,   // storing samples of the current field
        WS_HOLD = 2'd2    // sync seen, waiting for second showing to end
    } wr_state_e;

endpackage

// File: rtl/frc_sync2.sv
// Two-flop synchronizer for a single-bit level crossing into clk.
// Assumes the source level stays stable for at least two destination clocks.
module frc_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    // Two back-to-back flops, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/frc_wr_ctrl.sv
// Write-side controller. It turns the input vertical sync into a write
// pointer reset, then raises the write enable on every second wclk until
// FIELD_LEN samples are stored. If the reader is busy with a second showing,
// the pointer reset waits for it to finish. When a field completes, a toggle
// flag flips to tell the read side.
// Assumes in_vsync and rd_busy are asynchronous levels.
module frc_wr_ctrl
    import frc_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int FIELD_LEN = 256
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              in_vsync,
    input  logic [DATA_W-1:0] in_data,
    input  logic              rd_busy,
    output logic              wr_rst,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              field_tgl
);
    localparam int PTR_W = $clog2(FIELD_LEN + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(FIELD_LEN - 1);

    logic            vs_s, vs_d, busy_s, vs_rise;
    wr_state_e       state;
    logic [PTR_W-1:0] cnt;
    logic            phase;

    frc_sync2 u_sync_vs   (.clk(wclk), .rst_n(wrst_n), .d(in_vsync), .q(vs_s));
    frc_sync2 u_sync_busy (.clk(wclk), .rst_n(wrst_n), .d(rd_busy),  .q(busy_s));

    assign vs_rise = vs_s & ~vs_d;

    // Field fill sequencer: reset strobe, alternate-cycle enables, hold-off.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            vs_d      <= 1'b0;
            state     <= WS_IDLE;
            cnt       <= '0;
            phase     <= 1'b0;
            wr_rst    <= 1'b0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
            field_tgl <= 1'b0;
        end else begin
            vs_d   <= vs_s;
            wr_rst <= 1'b0;
            wr_en  <= 1'b0;
            if (vs_rise) begin
                if (busy_s) begin
                    state <= WS_HOLD;
                end else begin
                    wr_rst <= 1'b0 | 1'b1;
                    state  <= WS_FILL;
                    cnt    <= '0;
                    phase  <= 1'b0;
                end
            end else begin
                case (state)
                    WS_FILL: begin
                        phase <= ~phase;
                        if (phase) begin
                            wr_en   <= 1'b1;
                            wr_data <= in_data;
                            cnt     <= cnt + 1'b1;
                            if (cnt == LAST) begin
                                state     <= WS_IDLE;
                                field_tgl <= ~field_tgl;
                            end
                        end
                    end
                    WS_HOLD: begin
                        if (!busy_s) begin
                            wr_rst <= 1'b1;
                            state  <= WS_FILL;
                            cnt    <= '0;
                            phase  <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: an enable is never followed by another enable on the next cycle.
    assert_alt_enable_R2: assert property (@(posedge wclk) disable iff (!wrst_n)
        wr_en |=> !wr_en);

    // R6: a pointer reset is only issued when the reader was not busy.
    assert_holdoff_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
        wr_rst |-> !$past(busy_s));
endmodule

// File: rtl/frc_rd_ctrl.sv
// Read-side controller. Each output vertical sync resets the read pointer
// and then enables FIELD_LEN reads on consecutive rclk cycles. If a field has
// completed since the last replay, the showing is marked first (repeat 0);
// otherwise it is marked as a repeat. While a repeat is being read, a busy
// level goes to the write side. No replay starts before a field exists.
// Assumes out_vsync and field_tgl are asynchronous levels.
module frc_rd_ctrl #(
    parameter int FIELD_LEN = 256
) (
    input  logic rclk,
    input  logic rrst_n,
    input  logic out_vsync,
    input  logic field_tgl,
    output logic rd_rst,
    output logic rd_en,
    output logic rd_rep,
    output logic rd_busy
);
    localparam int PTR_W = $clog2(FIELD_LEN + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(FIELD_LEN - 1);

    logic             ovs_s, ovs_d, tgl_s, seen, have, active, start;
    logic [PTR_W-1:0] cnt;

    frc_sync2 u_sync_ovs (.clk(rclk), .rst_n(rrst_n), .d(out_vsync), .q(ovs_s));
    frc_sync2 u_sync_tgl (.clk(rclk), .rst_n(rrst_n), .d(field_tgl), .q(tgl_s));

    assign start = ovs_s & ~ovs_d & (have | (tgl_s ^ seen));

    // Replay sequencer: pointer reset, then FIELD_LEN read enables.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            ovs_d  <= 1'b0;
            seen   <= 1'b0;
            have   <= 1'b0;
            active <= 1'b0;
            cnt    <= '0;
            rd_rst <= 1'b0;
            rd_en  <= 1'b0;
            rd_rep <= 1'b0;
        end else begin
            ovs_d  <= ovs_s;
            rd_rst <= 1'b0;
            if (start) begin
                rd_rst <= 1'b1;
                rd_en  <= 1'b0;
                active <= 1'b1;
                cnt    <= '0;
                rd_rep <= ~(tgl_s ^ seen);
                seen   <= tgl_s;
                have   <= 1'b1;
            end else if (active) begin
                rd_en <= 1'b1;
                cnt   <= cnt + 1'b1;
                if (cnt == LAST) active <= 1'b0;
            end else begin
                rd_en <= 1'b0;
            end
        end
    end

    // Registered busy level for the write domain during a second showing.
    always_ff @(posedge rclk) begin
        if (!rrst_n) rd_busy <= 1'b0;
        else         rd_busy <= rd_rep & (active | rd_en);
    end

    // Checker: length of the current run of consecutive read enables.
    logic [PTR_W:0] chk_run;
    always_ff @(posedge rclk) begin
        if (!rrst_n)    chk_run <= '0;
        else if (rd_en) chk_run <= chk_run + 1'b1;
        else            chk_run <= '0;
    end

    // R4: a run of reads never exceeds one field.
    assert_run_len_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
        rd_en |-> (chk_run < (PTR_W+1)'(FIELD_LEN)));

    // R4: each run of reads is preceded by a pointer reset.
    assert_rst_first_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
        $rose(rd_en) |-> $past(rd_rst));
endmodule

// File: rtl/frc_field_mem.sv
// Behavioural dual-clock serial field memory. Each port has an internal
// pointer that a reset strobe sets to zero and an enable advances. A read
// returns its data one rclk after the enable, flagged by rvalid.
// Assumes the controllers never reset and enable a port in the same cycle.
module frc_field_mem #(
    parameter int DATA_W    = 12,
    parameter int FIELD_LEN = 256
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wrst,
    input  logic              wen,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rrst,
    input  logic              ren,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int PTR_W = $clog2(FIELD_LEN + 1);
    localparam int AW    = $clog2(FIELD_LEN);

    logic [DATA_W-1:0] mem [FIELD_LEN];
    logic [PTR_W-1:0]  wptr, rptr;

    // Write pointer: reset to zero or advance on each enable.
    always_ff @(posedge wclk) begin
        if (!wrst_n)   wptr <= '0;
        else if (wrst) wptr <= '0;
        else if (wen)  wptr <= wptr + 1'b1;
    end

    // Storage array written from the write port.
    always_ff @(posedge wclk) begin
        if (wen) mem[wptr[AW-1:0]] <= wdata;
    end

    // Read pointer, registered data and valid flag.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rptr   <= '0;
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= ren & ~rrst;
            if (rrst) begin
                rptr <= '0;
            end else if (ren) begin
                rdata <= mem[rptr[AW-1:0]];
                rptr  <= rptr + 1'b1;
            end
        end
    end

    // R3: reset and enable strobes never coincide on the write port.
    assert_no_rst_en_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
        !(wrst && wen));

    // R3: no write lands beyond the end of one field.
    assert_wptr_range_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
        wen |-> (wptr < PTR_W'(FIELD_LEN)));

    // R4: no read goes beyond the end of one field.
    assert_rptr_range_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
        ren |-> (rptr < PTR_W'(FIELD_LEN)));
endmodule

// File: rtl/frc_upconv.sv
// Top level of the field-repetition upconverter: write controller, read
// controller and the behavioural field memory between them.
// Assumes the two clocks are unrelated and each domain has its own reset.
module frc_upconv #(
    parameter int DATA_W    = 12,
    parameter int FIELD_LEN = 256
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              in_vsync,
    input  logic [DATA_W-1:0] in_data,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              out_vsync,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_repeat
);
    logic              wr_rst, wr_en, field_tgl;
    logic [DATA_W-1:0] wr_data;
    logic              rd_rst, rd_en, rd_busy;

    frc_wr_ctrl #(.DATA_W(DATA_W), .FIELD_LEN(FIELD_LEN)) u_wr (
        .wclk(wclk), .wrst_n(wrst_n), .in_vsync(in_vsync), .in_data(in_data),
        .rd_busy(rd_busy), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .field_tgl(field_tgl)
    );

    frc_rd_ctrl #(.FIELD_LEN(FIELD_LEN)) u_rd (
        .rclk(rclk), .rrst_n(rrst_n), .out_vsync(out_vsync),
        .field_tgl(field_tgl), .rd_rst(rd_rst), .rd_en(rd_en),
        .rd_rep(out_repeat), .rd_busy(rd_busy)
    );

    frc_field_mem #(.DATA_W(DATA_W), .FIELD_LEN(FIELD_LEN)) u_mem (
        .wclk(wclk), .wrst_n(wrst_n), .wrst(wr_rst), .wen(wr_en),
        .wdata(wr_data), .rclk(rclk), .rrst_n(rrst_n), .rrst(rd_rst),
        .ren(rd_en), .rdata(out_data), .rvalid(out_valid)
    );
endmodule

// File: tb/frc_upconv_tb_top.sv
`timescale 1ns/1ps
module frc_upconv_tb_top;
    localparam int DW = 12;
    localparam int FL = 32;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          wrst_n = 1'b0, rrst_n = 1'b0;
    logic          in_vsync = 1'b0, out_vsync = 1'b0;
    logic [DW-1:0] in_data;
    logic [DW-1:0] out_data;
    logic          out_valid, out_repeat;

    int            rhalf = 5;
    logic [5:0]    fld = 6'd0;
    logic [5:0]    tick = 6'd0;

    int            n_chk = 0, n_fail = 0;
    bit            done = 1'b0;

    int            rx_n;
    logic [DW-1:0] rx [64];
    logic          rx_rep [64];
    logic [DW-1:0] sv [64];

    frc_upconv #(.DATA_W(DW), .FIELD_LEN(FL)) dut_i (
        .wclk(wclk), .wrst_n(wrst_n), .in_vsync(in_vsync), .in_data(in_data),
        .rclk(rclk), .rrst_n(rrst_n), .out_vsync(out_vsync),
        .out_data(out_data), .out_valid(out_valid), .out_repeat(out_repeat)
    );

    always #4 wclk = ~wclk;
    always #(rhalf) rclk = ~rclk;

    // Source pattern: field number high, write-clock count low.
    always @(negedge wclk) tick <= tick + 6'd1;
    assign in_data = {fld, tick};

    // Capture replayed samples away from the active read edge.
    always @(negedge rclk) begin
        if (out_valid) begin
            if (rx_n < 64) begin
                rx[rx_n]     = out_data;
                rx_rep[rx_n] = out_repeat;
            end
            rx_n = rx_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_field(input logic [5:0] f);
        fld = f;
        in_vsync = 1'b1;
        repeat (4) @(negedge wclk);
        in_vsync = 1'b0;
        repeat (2*FL + 20) @(negedge wclk);
    endtask

    task automatic pulse_out();
        rx_n = 0;
        out_vsync = 1'b1;
        repeat (4) @(negedge rclk);
        out_vsync = 1'b0;
    endtask

    // Checks one captured replay against field number and showing index.
    task automatic verify(input logic [5:0] f, input bit rep, input bit cmp);
        int bad_f = 0, bad_s = 0, bad_r = 0, bad_c = 0;
        check(rx_n == FL, "R4 replay length", rx_n, FL);
        for (int k = 0; k < FL; k++) begin
            if (rx[k][11:6] != f) bad_f++;
            if (k > 0 && rx[k][5:0] != 6'(rx[k-1][5:0] + 6'd2)) bad_s++;
            if (rx_rep[k] != rep) bad_r++;
            if (cmp && rx[k] != sv[k]) bad_c++;
        end
        check(bad_f == 0, "R6 field number in replay", bad_f, 0);
        check(bad_s == 0, "R2 R3 sample step of two", bad_s, 0);
        check(bad_r == 0, "R5 out_repeat flag", bad_r, 0);
        if (cmp) check(bad_c == 0, "R5 second showing identical", bad_c, 0);
        for (int k = 0; k < 64; k++) sv[k] = rx[k];
    endtask

    initial begin
        rx_n = 0;
        repeat (6) @(negedge wclk);
        repeat (3) @(negedge rclk);
        wrst_n = 1'b1;
        rrst_n = 1'b1;
        @(negedge rclk);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

        // R7: output sync with no stored field.
        pulse_out();
        repeat (FL + 12) @(negedge rclk);
        check(rx_n == 0, "R7 no replay before first field", rx_n, 0);
        check(out_valid == 1'b0, "R1 out_valid idle", int'(out_valid), 0);

        // R4 R5: three read clock ratios.
        for (int i = 0; i < 3; i++) begin
            rhalf = (i == 0) ? 3 : (i == 1) ? 5 : 10;
            repeat (4) @(negedge wclk);
            write_field(6'(i + 1));
            pulse_out();
            repeat (FL + 12) @(negedge rclk);
            verify(6'(i + 1), 1'b0, 1'b0);
            pulse_out();
            repeat (FL + 12) @(negedge rclk);
            verify(6'(i + 1), 1'b1, 1'b1);
        end

        // R6: input sync during a second showing with a slow reader.
        rhalf = 10;
        write_field(6'd4);
        pulse_out();
        repeat (FL + 12) @(negedge rclk);
        verify(6'd4, 1'b0, 1'b0);
        pulse_out();
        repeat (8) @(negedge wclk);
        fld = 6'd5;
        in_vsync = 1'b1;
        repeat (4) @(negedge wclk);
        in_vsync = 1'b0;
        repeat (FL + 12) @(negedge rclk);
        verify(6'd4, 1'b1, 1'b1);
        repeat (2*FL + 40) @(negedge wclk);
        pulse_out();
        repeat (FL + 12) @(negedge rclk);
        verify(6'd5, 1'b0, 1'b0);
        pulse_out();
        repeat (FL + 12) @(negedge rclk);
        verify(6'd5, 1'b1, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge wclk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule